// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flags compare against: an empty offset and a full offset. While master reset is held it samples a mode pin and a two-bit select. The mode pin's level fixes the programming mode for the whole session: high selects serial and low selects parallel. The three pins together pick one of eight preset values, each a power of two minus one. That value is loaded into both offsets.

Once reset is released, driving the mode pin low opens a programming window. In this window a write strobe either shifts one bit from a serial input or loads a whole word from the parallel input, depending on the latched mode. A read strobe returns the current offsets one after the other on the parallel output. Serial readback does not exist in either mode. Driving the mode pin high closes the window and allows normal FIFO data traffic. Every value that enters an offset register is clamped to the largest legal offset, `MAX_OFS`.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst` is high, `serial_mode` takes the level of `mode_pin`: 1 for serial, 0 for parallel.
- R2: `serial_mode` keeps its value until `mrst` is asserted again.
- R3: During reset, both offsets load the preset chosen by {`mode_pin`, `dflt_sel[1]`, `dflt_sel[0]`}: 100→1023, 010→511, 001→255, 000→127, 011→63, 110→31, 101→15, 111→7. A preset above `MAX_OFS` is clamped to `MAX_OFS`.
- R4: Any value written to an offset that exceeds `MAX_OFS` is stored as `MAX_OFS`.
- R5: With the window open (`mode_pin` low, `mrst` low), a cycle with `rd_en` high puts an offset on `dout` and raises `dout_vld` in the following cycle. Successive reads alternate between the empty offset and the full offset, starting with the empty offset. This holds in both modes.
- R6: `fifo_access_ok` equals `mode_pin & ~mrst`. While `mode_pin` is high, `wr_en` and `rd_en` change neither offset nor `dout`.
- R7: In parallel mode, each `wr_en` in the window stores `din` into one offset. The empty offset is written first, then the full offset, and the two alternate after that.
- R8: In serial mode, each `wr_en` in the window shifts in one bit of `ser_in`. Bits arrive LSB first: 2·OFS_W bits in total, the empty offset followed by the full offset. Both offsets update together on the last bit, and a partial frame leaves them unchanged.
- R9: Master reset returns the write and read alternation to the empty offset and discards any partial serial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| mode_pin | input | 1 | Mode select during reset; low opens the programming window afterwards |
| dflt_sel | input | 2 | Preset select sampled during reset |
| wr_en | input | 1 | Offset write / shift strobe |
| rd_en | input | 1 | Offset readback strobe |
| ser_in | input | 1 | Serial offset bit |
| din | input | OFS_W | Parallel offset word |
| dout | output | OFS_W | Readback word |
| dout_vld | output | 1 | Readback word valid |
| serial_mode | output | 1 | Latched programming mode |
| fifo_access_ok | output | 1 | Normal FIFO traffic allowed |
| empty_ofs | output | OFS_W | Empty offset to flag logic |
| full_ofs | output | OFS_W | Full offset to flag logic |

## Verification
Two situations are hardest to reach from the ports. The first is a serial frame interrupted partway, and the second is a parallel write pointer left on the full offset when reset arrives. Neither is visible until a later access shows where the next value lands. The stimulus shifts all but the last bit and confirms the offsets are unchanged, then completes the frame. Separately it performs a single parallel write, pulses reset, and shows that the next write lands in the empty offset. The preset table is walked through every reset combination with a `MAX_OFS` below the largest preset, so clamping is exercised on the reset path as well as on writes.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W   = 10,
  parameter int MAX_OFS = (1 << OFS_W) - 1
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             mode_pin,
  input  logic [1:0]       dflt_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             ser_in,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] dout,
  output logic             dout_vld,
  output logic             serial_mode,
  output logic             fifo_access_ok,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  localparam int SH_W = 2 * OFS_W;
  localparam int CNT_W = $clog2(SH_W);
  localparam logic [OFS_W-1:0] MAXV = OFS_W'(MAX_OFS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SH_W - 1);

  function automatic logic [OFS_W-1:0] clamp(input logic [OFS_W-1:0] v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic logic [OFS_W-1:0] preset(input logic [2:0] code);
    int k;
    int v;
    case (code)
      3'b100:  k = 10;
      3'b010:  k = 9;
      3'b001:  k = 8;
      3'b000:  k = 7;
      3'b011:  k = 6;
      3'b110:  k = 5;
      3'b101:  k = 4;
      default: k = 3;
    endcase
    v = (1 << k) - 1;
    if (v > MAX_OFS) v = MAX_OFS;
    return OFS_W'(v);
  endfunction

  logic             prog;
  logic             wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [SH_W-1:0]  sh_nxt;

  assign prog           = ~mode_pin & ~mrst;
  assign fifo_access_ok = mode_pin & ~mrst;
  assign sh_nxt         = {ser_in, sh[SH_W-1:1]};

  always_ff @(posedge clk) begin
    if (mrst) begin
      serial_mode <= mode_pin;
      empty_ofs   <= preset({mode_pin, dflt_sel});
      full_ofs    <= preset({mode_pin, dflt_sel});
      wptr        <= 1'b0;
      rptr        <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      dout        <= '0;
      dout_vld    <= 1'b0;
    end else begin
      dout_vld <= prog & rd_en;
      if (prog && rd_en) begin
        dout <= rptr ? full_ofs : empty_ofs;
        rptr <= ~rptr;
      end
      if (prog && wr_en) begin
        if (serial_mode) begin
          sh <= sh_nxt;
          if (cnt == LAST) begin
            cnt       <= '0;
            empty_ofs <= clamp(sh_nxt[OFS_W-1:0]);
            full_ofs  <= clamp(sh_nxt[SH_W-1:OFS_W]);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (wptr) full_ofs <= clamp(din);
          else      empty_ofs <= clamp(din);
          wptr <= ~wptr;
        end
      end
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(serial_mode)); // R2
  AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (mrst)
    (empty_ofs <= MAXV) && (full_ofs <= MAXV)); // R4
  AST_CLOSED_NO_CHANGE: assert property (@(posedge clk) disable iff (mrst)
    mode_pin |=> $stable(empty_ofs) && $stable(full_ofs)); // R6
  AST_READ_VALID: assert property (@(posedge clk) disable iff (mrst)
    (!mode_pin && rd_en) |=> dout_vld); // R5
  AST_PAR_ONE_REG: assert property (@(posedge clk) disable iff (mrst)
    (!serial_mode && !mode_pin && wr_en) |=> ($stable(empty_ofs) || $stable(full_ofs))); // R7
endmodule

// File: tb/flag_offset_loader_tb.sv
`timescale 1ns/1ps
module flag_offset_loader_tb_top;
  localparam int W = 11;
  localparam int MX = 1000;

  logic clk = 0, mrst = 1, mode_pin = 0, wr_en = 0, rd_en = 0, ser_in = 0;
  logic [1:0] dflt_sel = 0;
  logic [W-1:0] din = 0, dout, empty_ofs, full_ofs;
  logic dout_vld, serial_mode, fifo_access_ok;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_offset_loader #(.OFS_W(W), .MAX_OFS(MX)) dut_i (
    .clk(clk), .mrst(mrst), .mode_pin(mode_pin), .dflt_sel(dflt_sel),
    .wr_en(wr_en), .rd_en(rd_en), .ser_in(ser_in), .din(din),
    .dout(dout), .dout_vld(dout_vld), .serial_mode(serial_mode),
    .fifo_access_ok(fifo_access_ok), .empty_ofs(empty_ofs), .full_ofs(full_ofs));

  // {mode_pin, sel1, sel0, expected preset after clamp to MX}
  localparam logic [13:0] VEC [8] = '{
    {3'b100, 11'd1000}, {3'b010, 11'd511}, {3'b001, 11'd255}, {3'b000, 11'd127},
    {3'b011, 11'd63},   {3'b110, 11'd31},  {3'b101, 11'd15},  {3'b111, 11'd7}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [1:0] s);
    mrst = 1; mode_pin = m; dflt_sel = s;
    @(negedge clk); @(negedge clk);
    mrst = 0; mode_pin = 0;
    @(negedge clk);
  endtask

  task automatic pwrite(input int v);
    din = W'(v); wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic pread(input string req, input int exp);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk({req, " vld"}, dout_vld, 1);
    chk(req, dout, exp);
  endtask

  task automatic sbit(input logic b);
    ser_in = b; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  initial begin
    @(negedge clk);
    // Table of reset presets
    foreach (VEC[i]) begin
      do_reset(VEC[i][13], VEC[i][12:11]);
      chk("R1 mode latch", serial_mode, VEC[i][13]);
      chk("R3 preset empty", empty_ofs, VEC[i][10:0]);
      chk("R3 preset full", full_ofs, VEC[i][10:0]);
      pread("R5 read empty", VEC[i][10:0]);
      pread("R5 read full", VEC[i][10:0]);
    end

    // Parallel mode
    do_reset(1'b0, 2'b00);
    chk("R1 parallel", serial_mode, 0);
    chk("R6 access closed", fifo_access_ok, 0);
    pwrite(5);
    chk("R7 first write empty", empty_ofs, 5);
    chk("R7 full untouched", full_ofs, 127);
    pwrite(2000);
    chk("R4 clamp full", full_ofs, MX);
    pwrite(9);
    chk("R7 alternates to empty", empty_ofs, 9);
    pread("R5 readback empty", 9);
    pread("R5 readback full", MX);
    pread("R5 alternates", 9);
    mode_pin = 1;
    @(negedge clk);
    chk("R6 access open", fifo_access_ok, 1);
    din = 77; wr_en = 1; rd_en = 1; @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R6 closed write empty", empty_ofs, 9);
    chk("R6 closed write full", full_ofs, MX);
    chk("R6 closed no read", dout_vld, 0);
    chk("R6 dout held", dout, 9);
    mode_pin = 0;
    chk("R2 mode held", serial_mode, 0);
    // R9: leave write pointer at full, then reset
    do_reset(1'b0, 2'b11);
    pwrite(40);
    do_reset(1'b0, 2'b11);
    pwrite(41);
    chk("R9 write ptr reset", empty_ofs, 41);
    chk("R9 full preset kept", full_ofs, 63);
    pread("R9 read ptr first", 41);
    do_reset(1'b0, 2'b11);
    pread("R9 read ptr reset", 63);

    // Serial mode
    do_reset(1'b1, 2'b00);
    chk("R1 serial", serial_mode, 1);
    begin
      logic [2*W-1:0] frame;
      frame = {11'd600, 11'd37};
      for (int i = 0; i < 2*W-1; i++) sbit(frame[i]);
      chk("R8 partial empty", empty_ofs, 1000);
      chk("R8 partial full", full_ofs, 1000);
      sbit(frame[2*W-1]);
      chk("R8 frame empty", empty_ofs, 37);
      chk("R8 frame full", full_ofs, 600);
      pread("R5 serial read empty", 37);
      pread("R5 serial read full", 600);
      frame = {11'd2047, 11'd3};
      for (int i = 0; i < 2*W; i++) sbit(frame[i]);
      chk("R4 serial clamp", full_ofs, MX);
      chk("R8 second frame", empty_ofs, 3);
      // R9: partial frame discarded by reset
      for (int i = 0; i < 5; i++) sbit(1'b1);
      do_reset(1'b1, 2'b00);
      frame = {11'd200, 11'd100};
      for (int i = 0; i < 2*W; i++) sbit(frame[i]);
      chk("R9 frame realigned empty", empty_ofs, 100);
      chk("R9 frame realigned full", full_ofs, 200);
    end
    mode_pin = 1;
    @(negedge clk);
    chk("R2 serial held", serial_mode, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule